// File: doc/BRIEF.md
# Stack Push/Pop Transfer Sequencer

This block carries out the compact 16-bit stack instruction that saves or restores a group of low registers. A start strobe hands it the instruction word and the current stack pointer. The block then works out how many words it has to move. It issues one 32-bit memory access per transfer over a request/ready port, using one read or write port of the register file, and on completion presents the new stack pointer.

A save (push) first lowers the stack pointer by the whole transfer size. It then stores upward from that new address, so the lowest-numbered register sits at the lowest address. A restore (pop) reads upward from the current stack pointer. A flag bit adds the link register to a save, or the program counter to a restore. A restored program counter has bit 0 cleared, and the block raises a pipeline flush request when it ends.

Top module: `stack_xfer_seq`

## Requirements
- R1: The instruction word is decoded as follows: bit 11 is 1 for a restore (pop) and 0 for a save (push), bit 8 is the extra flag, and bits 7:0 select registers 0 to 7 (bit n selects register n).
- R2: A restore reads the selected registers in ascending register order from consecutive words, starting at the incoming stack pointer and stepping 4 bytes per word. It writes each word to its register and leaves registers that are not selected untouched.
- R3: A restore with the flag set reads one more word after the last register into register index 15 (the program counter), with bit 0 written as 0. The final stack pointer includes that word, and `flush` is high in the `done` cycle.
- R4: A save ends with the stack pointer equal to the incoming value minus 4 times the number of words stored. When the flag is set, that number counts the link register (index 14).
- R5: A save writes the selected registers in ascending order from the lowered stack pointer upward. The link register, when present, goes last at the highest address.
- R6: `extra_cycle` is 1 in the `done` cycle of a restore and 0 in the `done` cycle of a save.
- R7: An empty register list with the flag clear makes no memory access and never asserts `sp_we`. `done` is high in the cycle after start is taken.
- R8: While `mem_req` is high and `mem_ready` is low, the request, address, direction and write data stay unchanged in the next cycle. The block moves to the next word only on a completed access.
- R9: `done` is high for exactly one cycle, after the last completed access. `busy` stays high from the cycle after start until that cycle.
- R10: A start strobe seen while `busy` is high is ignored and does not change the transfer in progress.
- R11: During reset `busy`, `done`, `mem_req`, `rf_we`, `sp_we` and `flush` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| instr | input | 16 | Stack instruction word |
| sp_in | input | 32 | Current stack pointer |
| sp_out | output | 32 | Updated stack pointer |
| sp_we | output | 1 | Write strobe for `sp_out` |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (same cycle) |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| rf_we | output | 1 | Register file write strobe |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address (byte units) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| flush | output | 1 | Pipeline flush request (with `done`) |
| extra_cycle | output | 1 | Extra internal cycle reported (with `done`) |

## Verification
The hardest situation to reach from the ports is a second start arriving in the middle of a long, stalled transfer that then completes normally. The bench holds `start` high with a conflicting restore instruction for two cycles while the memory model stretches every access with wait states. It then compares the whole access trace against what the first instruction alone would produce. The wait-state count in the vector table also holds requests pending for several cycles, so the stability rule is exercised on both reads and writes. Odd memory words make the cleared bit 0 of a restored program counter visible.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  localparam int unsigned REG_IDX_W = 4;
  localparam logic [REG_IDX_W-1:0] LINK_IDX = 4'd14;
  localparam logic [REG_IDX_W-1:0] PCNT_IDX = 4'd15;

endpackage

// File: rtl/stk_list_scan.sv
module stk_list_scan #(
  parameter int unsigned SLOT_W = 9,
  localparam int unsigned IDX_W = $clog2(SLOT_W),
  localparam int unsigned CNT_W = $clog2(SLOT_W + 1)
) (
  input  logic [SLOT_W-1:0] mask,
  output logic [SLOT_W-1:0] first_oh,
  output logic [IDX_W-1:0]  first_idx,
  output logic [CNT_W-1:0]  count,
  output logic              last
);

  logic [SLOT_W-1:0] below_any;

  assign below_any[0] = 1'b0;
  assign first_oh[0]  = mask[0];

  genvar g;
  generate
    for (g = 1; g < SLOT_W; g++) begin : g_prio
      assign below_any[g] = below_any[g-1] | mask[g-1];
      assign first_oh[g]  = mask[g] & ~below_any[g];
    end
  endgenerate

  always_comb begin
    first_idx = '0;
    count     = '0;
    for (int i = 0; i < SLOT_W; i++) begin
      if (first_oh[i]) first_idx = IDX_W'(i);
      count = count + CNT_W'(mask[i]);
    end
  end

  assign last = (count == CNT_W'(1));

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] sp,
  input  logic              is_pop,
  input  logic [CNT_W-1:0]  nwords,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] end_sp
);

  logic [ADDR_W-1:0] span;

  assign span = ADDR_W'(nwords) * ADDR_W'(WORD_BYTES);

  always_comb begin
    if (is_pop) begin
      first_addr = sp;
      end_sp     = sp + span;
    end else begin
      first_addr = sp - span;
      end_sp     = sp - span;
    end
  end

endmodule

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq
  import stk_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INSTR_W    = 16,
  parameter int unsigned LIST_W     = 8,
  parameter int unsigned POP_BIT    = 11,
  parameter int unsigned FLAG_BIT   = 8,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [ADDR_W-1:0]    sp_in,
  output logic [ADDR_W-1:0]    sp_out,
  output logic                 sp_we,
  output logic [REG_IDX_W-1:0] rf_raddr,
  input  logic [DATA_W-1:0]    rf_rdata,
  output logic [REG_IDX_W-1:0] rf_waddr,
  output logic [DATA_W-1:0]    rf_wdata,
  output logic                 rf_we,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  input  logic                 mem_ready,
  output logic                 busy,
  output logic                 done,
  output logic                 flush,
  output logic                 extra_cycle
);

  localparam int unsigned SLOT_W = LIST_W + 1;
  localparam int unsigned IDX_W  = $clog2(SLOT_W);
  localparam int unsigned CNT_W  = $clog2(SLOT_W + 1);

  // state
  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] mask_q, mask_d;
  logic              pop_q, pop_d;
  logic              flag_q, flag_d;
  logic              some_q, some_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] end_sp_q, end_sp_d;
  logic              ld_en, step_en;

  // incoming decode
  logic              in_pop, in_flag;
  logic [SLOT_W-1:0] in_mask;
  logic [SLOT_W-1:0] in_first_oh;
  logic [IDX_W-1:0]  in_first_idx;
  logic [CNT_W-1:0]  in_count;
  logic              in_last;
  logic [ADDR_W-1:0] in_first_addr, in_end_sp;

  // current slot
  logic [SLOT_W-1:0] cur_oh;
  logic [IDX_W-1:0]  cur_idx;
  logic [CNT_W-1:0]  cur_count;
  logic              cur_last;
  logic [REG_IDX_W-1:0] cur_reg;
  logic              xfer_ok;

  logic unused_bits;
  assign unused_bits = ^{instr, in_first_oh, in_first_idx, in_last, cur_count};

  assign in_pop  = instr[POP_BIT];
  assign in_flag = instr[FLAG_BIT];
  assign in_mask = {in_flag, instr[LIST_W-1:0]};

  stk_list_scan #(.SLOT_W(SLOT_W)) u_scan_in (
    .mask      (in_mask),
    .first_oh  (in_first_oh),
    .first_idx (in_first_idx),
    .count     (in_count),
    .last      (in_last)
  );

  stk_list_scan #(.SLOT_W(SLOT_W)) u_scan_cur (
    .mask      (mask_q),
    .first_oh  (cur_oh),
    .first_idx (cur_idx),
    .count     (cur_count),
    .last      (cur_last)
  );

  stk_addr_gen #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_agen (
    .sp         (sp_in),
    .is_pop     (in_pop),
    .nwords     (in_count),
    .first_addr (in_first_addr),
    .end_sp     (in_end_sp)
  );

  // slot to register index: low slots map directly, the top slot is LR or PC
  always_comb begin
    if (cur_idx < IDX_W'(LIST_W)) cur_reg = REG_IDX_W'(cur_idx);
    else                          cur_reg = pop_q ? PCNT_IDX : LINK_IDX;
  end

  assign xfer_ok = (state_q == ST_XFER) && mem_ready;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    mask_d   = mask_q;
    pop_d    = pop_q;
    flag_d   = flag_q;
    some_d   = some_q;
    addr_d   = addr_q;
    end_sp_d = end_sp_q;
    ld_en    = 1'b0;
    step_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          ld_en    = 1'b1;
          mask_d   = in_mask;
          pop_d    = in_pop;
          flag_d   = in_flag;
          some_d   = (in_count != '0);
          addr_d   = in_first_addr;
          end_sp_d = in_end_sp;
          state_d  = (in_count != '0) ? ST_XFER : ST_FIN;
        end
      end
      ST_XFER: begin
        if (mem_ready) begin
          step_en = 1'b1;
          mask_d  = mask_q & ~cur_oh;
          addr_d  = addr_q + ADDR_W'(WORD_BYTES);
          if (cur_last) state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mask_q   <= '0;
      pop_q    <= 1'b0;
      flag_q   <= 1'b0;
      some_q   <= 1'b0;
      addr_q   <= '0;
      end_sp_q <= '0;
    end else begin
      state_q <= state_d;
      if (ld_en) begin
        pop_q    <= pop_d;
        flag_q   <= flag_d;
        some_q   <= some_d;
        end_sp_q <= end_sp_d;
      end
      if (ld_en || step_en) begin
        mask_q <= mask_d;
        addr_q <= addr_d;
      end
    end
  end

  // outputs
  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_FIN);
  assign sp_we       = done && some_q;
  assign sp_out      = end_sp_q;
  assign flush       = done && pop_q && flag_q;
  assign extra_cycle = done && pop_q;

  assign mem_req   = (state_q == ST_XFER);
  assign mem_we    = !pop_q;
  assign mem_addr  = addr_q;
  assign rf_raddr  = cur_reg;
  assign mem_wdata = rf_rdata;

  assign rf_we    = xfer_ok && pop_q;
  assign rf_waddr = cur_reg;
  always_comb begin
    rf_wdata = mem_rdata;
    if (cur_reg == PCNT_IDX) rf_wdata[0] = 1'b0;
  end

  // assertions
  a_r8_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && busy && !done && cur_count > CNT_W'(1))
      |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r7_no_idle_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !rf_we && !sp_we));

  a_r3_flush_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (done && extra_cycle));

  a_r3_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_waddr == PCNT_IDX) |-> !rf_wdata[0]);

  a_r5_link_last: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && rf_raddr == LINK_IDX && mem_ready) |=> done);

  a_r2_load_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_req && mem_ready && !mem_we));

endmodule

// File: tb/stack_xfer_seq_tb.sv
module stack_xfer_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] instr;
  logic [31:0] sp_in;
  logic [31:0] sp_out;
  logic        sp_we;
  logic [3:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        rf_we;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ready;
  logic        busy;
  logic        done;
  logic        flush;
  logic        extra_cycle;

  stack_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .sp_in(sp_in), .sp_out(sp_out), .sp_we(sp_we),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .rf_we(rf_we),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .flush(flush), .extra_cycle(extra_cycle)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bench models: register file, memory, stack pointer, access log
  logic [31:0] tb_rf  [16];
  logic [31:0] tb_mem [64];
  logic [31:0] tb_sp;
  logic [31:0] acc_addr [16];
  logic        acc_we   [16];
  int          acc_n;
  int          spwe_n;
  int          stall;
  int          wait_cfg;
  logic [31:0] sp0_cfg;
  logic        reload;

  function automatic logic [31:0] reg_init(int i);
    return 32'hA000_0000 | (32'(i) << 8) | 32'(i);
  endfunction
  function automatic logic [31:0] mem_init(int w);
    return 32'hC000_0001 + (32'(w) << 4);
  endfunction

  assign rf_rdata  = tb_rf[rf_raddr];
  assign mem_rdata = tb_mem[mem_addr[7:2]];
  assign mem_ready = mem_req && (stall >= wait_cfg);
  assign sp_in     = tb_sp;

  always @(posedge clk) begin
    if (reload) begin
      for (int i = 0; i < 16; i++) tb_rf[i] <= reg_init(i);
      for (int w = 0; w < 64; w++) tb_mem[w] <= mem_init(w);
      tb_sp  <= sp0_cfg;
      acc_n  <= 0;
      spwe_n <= 0;
      stall  <= 0;
    end else begin
      if (mem_req && mem_ready) begin
        stall <= 0;
        if (acc_n < 16) begin
          acc_addr[acc_n] <= mem_addr;
          acc_we[acc_n]   <= mem_we;
        end
        acc_n <= acc_n + 1;
        if (mem_we) tb_mem[mem_addr[7:2]] <= mem_wdata;
      end else if (mem_req) begin
        stall <= stall + 1;
      end
      if (rf_we) tb_rf[rf_waddr] <= rf_wdata;
      if (sp_we) begin
        tb_sp  <= sp_out;
        spwe_n <= spwe_n + 1;
      end
    end
  end

  int n_chk;
  int n_bad;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // vector table: {instr[15:0], sp[31:0], wait[3:0]}
  localparam int NVEC = 8;
  localparam logic [51:0] VEC [NVEC] = '{
    {16'h0007, 32'h0000_00C0, 4'd0},
    {16'h0190, 32'h0000_00F0, 4'd2},
    {16'h01FF, 32'h0000_00F0, 4'd1},
    {16'h0100, 32'h0000_0080, 4'd0},
    {16'h080A, 32'h0000_0040, 4'd0},
    {16'h0921, 32'h0000_0060, 4'd3},
    {16'h0900, 32'h0000_0020, 4'd1},
    {16'h08FF, 32'h0000_0010, 4'd2}
  };

  task automatic run_vec(input logic [15:0] ins, input logic [31:0] sp0,
                         input int wt, input bit intrude);
    bit          is_pop, flg;
    int          nw, cyc;
    int          regs [9];
    logic [31:0] base, exp_sp, a;
    bit          ok;

    is_pop = ins[11];
    flg    = ins[8];
    nw     = 0;
    for (int r = 0; r < 8; r++) if (ins[r]) begin regs[nw] = r; nw++; end
    if (flg) begin regs[nw] = is_pop ? 15 : 14; nw++; end
    exp_sp = is_pop ? sp0 + 32'(4 * nw) : sp0 - 32'(4 * nw);
    base   = is_pop ? sp0 : exp_sp;

    @(negedge clk);
    wait_cfg = wt;
    sp0_cfg  = sp0;
    reload   = 1'b1;
    @(negedge clk);
    reload = 1'b0;
    start  = 1'b1;
    instr  = ins;
    @(negedge clk);
    if (intrude) begin
      instr = 16'h08FF;  // conflicting pop while busy (R10)
      for (int k = 0; k < 2; k++) begin
        check(busy === 1'b1, "R9", "busy after start", 32'(busy), 32'd1);
        @(negedge clk);
      end
    end
    start = 1'b0;
    cyc = 0;
    while (done !== 1'b1 && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    check(done === 1'b1, "R9", "done reached", 32'(done), 32'd1);
    if (nw == 0)
      check(cyc == 0, "R7", "empty list latency", 32'(cyc), 32'd0);
    check(flush === (is_pop && flg), "R3", "flush in done cycle",
          32'(flush), 32'(is_pop && flg));
    check(extra_cycle === is_pop, "R6", "extra cycle flag",
          32'(extra_cycle), 32'(is_pop));
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R9", "done one cycle then idle",
          {30'd0, done, busy}, 32'd0);
    check(tb_sp === exp_sp, is_pop ? "R2" : "R4", "final stack pointer",
          tb_sp, exp_sp);
    check(spwe_n == (nw == 0 ? 0 : 1), "R7", "sp write count",
          32'(spwe_n), 32'(nw == 0 ? 0 : 1));
    check(acc_n == nw, intrude ? "R10" : "R8", "access count",
          32'(acc_n), 32'(nw));
    ok = 1'b1;
    for (int k = 0; k < nw && k < acc_n; k++) begin
      a = base + 32'(4 * k);
      if (acc_addr[k] !== a || acc_we[k] !== !is_pop) begin
        ok = 1'b0;
        check(1'b0, is_pop ? "R2" : "R5", "access address order", acc_addr[k], a);
      end
    end
    if (ok) check(1'b1, "R5", "access order", 32'd0, 32'd0);
    for (int k = 0; k < nw; k++) begin
      a = base + 32'(4 * k);
      if (is_pop) begin
        if (regs[k] == 15)
          check(tb_rf[15] === (mem_init(int'(a[7:2])) & ~32'd1), "R3",
                "popped PC", tb_rf[15], mem_init(int'(a[7:2])) & ~32'd1);
        else
          check(tb_rf[regs[k]] === mem_init(int'(a[7:2])), "R2",
                "popped register", tb_rf[regs[k]], mem_init(int'(a[7:2])));
      end else begin
        check(tb_mem[a[7:2]] === reg_init(regs[k]), regs[k] == 14 ? "R5" : "R4",
              "pushed word", tb_mem[a[7:2]], reg_init(regs[k]));
      end
    end
    if (is_pop) begin
      for (int r = 0; r < 8; r++)
        if (!ins[r])
          check(tb_rf[r] === reg_init(r), "R2", "unselected register kept",
                tb_rf[r], reg_init(r));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk    = 0;
    n_bad    = 0;
    rst_n    = 1'b0;
    start    = 1'b0;
    instr    = '0;
    reload   = 1'b1;
    wait_cfg = 0;
    sp0_cfg  = 32'h80;
    repeat (3) @(negedge clk);
    // R11 reset state
    check({busy, done, mem_req, rf_we, sp_we, flush} === 6'b0, "R11",
          "reset outputs", {26'd0, busy, done, mem_req, rf_we, sp_we, flush}, 32'd0);
    rst_n  = 1'b1;
    reload = 1'b0;
    @(negedge clk);
    check(busy === 1'b0, "R11", "idle after reset", 32'(busy), 32'd0);

    // R1 decode exercised through every table entry
    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][51:36], VEC[v][35:4], int'(VEC[v][3:0]), 1'b0);

    // R7 empty list, push and pop forms
    run_vec(16'h0000, 32'h0000_0050, 0, 1'b0);
    run_vec(16'h0800, 32'h0000_0050, 0, 1'b0);
    // R10 start held with a conflicting instruction while busy
    run_vec(16'h0085, 32'h0000_00A0, 3, 1'b1);
    // R8 long stalls on a pop with PC
    run_vec(16'h09C3, 32'h0000_0030, 6, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule